// File: doc/BRIEF.md
# UART Modem Handshake Register Section

This block is the modem-handshake slice of one UART channel's register file. Software reaches it through a small synchronous register port with a 3-bit address and an 8-bit data bus. A control register drives the active-low terminal-ready and request-to-send lines, a user output, and the enable of the channel's interrupt pad driver. It also selects an internal loopback of the serial lines.

The four active-low modem inputs are clear-to-send, data-set-ready, ring indicator and carrier detect. Each passes through a multi-flop synchronizer. Their inverted levels can be read from a status register, together with sticky change flags that clear on read. An interrupt enable register gates four request sources: three from the neighbouring receive and transmit logic and one from the pending modem change flags. The enabled requests are combined into one registered interrupt level.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset, term_rdy_n, req_send_n and user_out are 1, irq_drive_en is 0, irq_level is 0, ser_tx_pin is 1, and the enable, control and status registers all read 0 while every modem input is held high.
- R2: Writing the control register (address 4) with bit 0 set drives term_rdy_n low after that write's clock edge. Writing bit 0 clear drives it high.
- R3: Control bit 1 set drives req_send_n low. Control bit 1 clear drives it high.
- R4: Control bit 3 set makes irq_drive_en 1 and user_out 0. Control bit 3 clear makes irq_drive_en 0 and user_out 1.
- R5: Status register (address 6) bits 7:4 read the inverted synchronized levels of clear-to-send (bit 4), data-set-ready (bit 5), ring indicator (bit 6) and carrier detect (bit 7).
- R6: Any level change on clear-to-send, data-set-ready or carrier detect sets status bit 0, 1 or 3 respectively, in either direction.
- R7: Status bit 2 is set only when the ring-indicator input goes from low to high. A high-to-low change sets no flag.
- R8: A read of the status register clears bits 3:0 after returning them. Bits 7:4 keep following the inputs.
- R9: With enable bit 3 set, any pending status flag in bits 3:0 drives irq_level to 1. With enable bit 3 clear, modem changes leave irq_level at 0.
- R10: Enable bits 0, 1 and 2 gate the requests rx_avail_req, tx_space_req and rx_error_req. irq_level is the registered OR of all enabled requests.
- R11: Control bit 4 selects loopback. In loopback, ser_tx_pin is held at 1 and ser_rx_out follows ser_tx_in, so ser_rx_pin has no effect. Otherwise ser_tx_pin follows ser_tx_in and ser_rx_out follows ser_rx_pin. Each path has one register of latency.
- R12: The enable register (address 1) reads back its low 4 bits and the control register reads back its low 5 bits, with the unused upper bits as 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read data is registered |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| term_rdy_n | output | 1 | Terminal-ready, active low |
| req_send_n | output | 1 | Request-to-send, active low |
| user_out | output | 1 | User output, inverse of control bit 3 |
| irq_drive_en | output | 1 | Output enable for the interrupt pad driver |
| irq_level | output | 1 | Interrupt level for the pad driver, active high |
| rx_avail_req | input | 1 | Receive-data-available request |
| tx_space_req | input | 1 | Transmit-space-available request |
| rx_error_req | input | 1 | Receiver-error request |
| ser_tx_in | input | 1 | Serial data from the transmitter |
| ser_tx_pin | output | 1 | Serial transmit pin |
| ser_rx_pin | input | 1 | Serial receive pin |
| ser_rx_out | output | 1 | Serial data to the receiver |

## Verification
The bench builds the block with its default two-stage synchronizer and 3-bit address. Every modem input change therefore reaches the status register three edges after it is driven, and the bench can wait a short fixed window before reading. The 3-bit address lets the bench reach every unmapped location, including the highest one. The 8-bit data bus lets it write all-ones patterns and confirm that the unused upper bits of the enable and control registers read back as zero.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int REG_W = 8;

  localparam logic [2:0] ADDR_IER = 3'd1;
  localparam logic [2:0] ADDR_MCR = 3'd4;
  localparam logic [2:0] ADDR_MSR = 3'd6;

  localparam int MCR_BITS = 5;
  localparam int IER_BITS = 4;
  localparam int MDM_LINES = 4;

  localparam int MCR_DTR  = 0;
  localparam int MCR_RTS  = 1;
  localparam int MCR_IRQE = 3;
  localparam int MCR_LOOP = 4;

  localparam int IER_RXA = 0;
  localparam int IER_TXS = 1;
  localparam int IER_RXE = 2;
  localparam int IER_MDM = 3;

  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int STAGES = 2,
  parameter int W      = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [MDM_LINES-1:0] lines_n,
  input  logic                 rd_clr,
  output logic [REG_W-1:0]     msr,
  output logic                 pend,
  output logic [MDM_LINES-1:0] chg,
  output logic                 ri_prev
);
  logic [MDM_LINES-1:0] lvl;
  logic [MDM_LINES-1:0] prev_q;
  logic [MDM_LINES-1:0] delta_q;

  mdm_sync #(.STAGES(SYNC_STAGES), .W(MDM_LINES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst(rst), .d(lines_n), .q(lvl)
  );

  generate
    for (genvar i = 0; i < MDM_LINES; i++) begin : g_det
      if (i == LN_RI) begin : g_trail
        assign chg[i] = lvl[i] & ~prev_q[i];
      end else begin : g_any
        assign chg[i] = lvl[i] ^ prev_q[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '1;
      delta_q <= '0;
    end else begin
      prev_q  <= lvl;
      delta_q <= (rd_clr ? '0 : delta_q) | chg;
    end
  end

  assign msr     = {~lvl, delta_q};
  assign pend    = |delta_q;
  assign ri_prev = prev_q[LN_RI];
endmodule

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_ier,
  input  logic                wr_mcr,
  input  logic [REG_W-1:0]    wdata,
  input  logic [2:0]          src_req,
  input  logic                msr_pend,
  input  logic                ser_tx_in,
  input  logic                ser_rx_pin,
  output logic [IER_BITS-1:0] ier_q,
  output logic [MCR_BITS-1:0] mcr_q,
  output logic                term_rdy_n,
  output logic                req_send_n,
  output logic                user_out,
  output logic                irq_drive_en,
  output logic                irq_level,
  output logic                ser_tx_pin,
  output logic                ser_rx_out
);
  logic [IER_BITS-1:0] req_vec;
  logic                irq_q, txp_q, rxo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q <= '0;
      mcr_q <= '0;
    end else begin
      if (wr_ier) ier_q <= wdata[IER_BITS-1:0];
      if (wr_mcr) mcr_q <= wdata[MCR_BITS-1:0];
    end
  end

  assign req_vec = {msr_pend, src_req[2], src_req[1], src_req[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      txp_q <= 1'b1;
      rxo_q <= 1'b1;
    end else begin
      irq_q <= |(req_vec & ier_q);
      txp_q <= mcr_q[MCR_LOOP] ? 1'b1 : ser_tx_in;
      rxo_q <= mcr_q[MCR_LOOP] ? ser_tx_in : ser_rx_pin;
    end
  end

  assign term_rdy_n   = ~mcr_q[MCR_DTR];
  assign req_send_n   = ~mcr_q[MCR_RTS];
  assign irq_drive_en = mcr_q[MCR_IRQE];
  assign user_out     = ~mcr_q[MCR_IRQE];
  assign irq_level    = irq_q;
  assign ser_tx_pin   = txp_q;
  assign ser_rx_out   = rxo_q;
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic              term_rdy_n,
  output logic              req_send_n,
  output logic              user_out,
  output logic              irq_drive_en,
  output logic              irq_level,
  input  logic              rx_avail_req,
  input  logic              tx_space_req,
  input  logic              rx_error_req,
  input  logic              ser_tx_in,
  output logic              ser_tx_pin,
  input  logic              ser_rx_pin,
  output logic              ser_rx_out
);
  localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(ADDR_IER);
  localparam logic [ADDR_W-1:0] A_MCR = ADDR_W'(ADDR_MCR);
  localparam logic [ADDR_W-1:0] A_MSR = ADDR_W'(ADDR_MSR);

  logic                 wr_ier, wr_mcr, rd_msr;
  logic [IER_BITS-1:0]  ier_q;
  logic [MCR_BITS-1:0]  mcr_q;
  logic [REG_W-1:0]     msr_q;
  logic                 msr_pend;
  logic [MDM_LINES-1:0] chg;
  logic                 ri_prev;
  logic [MDM_LINES-1:0] lines_n;
  logic [REG_W-1:0]     rdata_q;

  assign wr_ier = reg_wr && (reg_addr == A_IER);
  assign wr_mcr = reg_wr && (reg_addr == A_MCR);
  assign rd_msr = reg_rd && (reg_addr == A_MSR);

  always_comb begin
    lines_n         = '1;
    lines_n[LN_CTS] = cts_n;
    lines_n[LN_DSR] = dsr_n;
    lines_n[LN_RI]  = ri_n;
    lines_n[LN_DCD] = dcd_n;
  end

  mdm_status #(.SYNC_STAGES(SYNC_STAGES)) u_stat (
    .clk(clk), .rst(rst), .lines_n(lines_n), .rd_clr(rd_msr),
    .msr(msr_q), .pend(msr_pend), .chg(chg), .ri_prev(ri_prev)
  );

  mdm_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_ier(wr_ier), .wr_mcr(wr_mcr),
    .wdata(reg_wdata),
    .src_req({rx_error_req, tx_space_req, rx_avail_req}),
    .msr_pend(msr_pend), .ser_tx_in(ser_tx_in), .ser_rx_pin(ser_rx_pin),
    .ier_q(ier_q), .mcr_q(mcr_q),
    .term_rdy_n(term_rdy_n), .req_send_n(req_send_n),
    .user_out(user_out), .irq_drive_en(irq_drive_en),
    .irq_level(irq_level), .ser_tx_pin(ser_tx_pin), .ser_rx_out(ser_rx_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        A_IER:   rdata_q <= REG_W'(ier_q);
        A_MCR:   rdata_q <= REG_W'(mcr_q);
        A_MSR:   rdata_q <= msr_q;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/mdm_chk.sv
module mdm_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              term_rdy_n,
  input logic              req_send_n,
  input logic              user_out,
  input logic              irq_drive_en,
  input logic              irq_level,
  input logic              ser_tx_pin,
  input logic              loop_q,
  input logic [3:0]        ier_q,
  input logic [3:0]        delta,
  input logic [3:0]        chg,
  input logic              ri_prev
);
  localparam logic [ADDR_W-1:0] A_MCR = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MSR = ADDR_W'(6);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (term_rdy_n && req_send_n && user_out && !irq_drive_en && ser_tx_pin && !irq_level));

  assert_dtr_write_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_MCR) |=> (term_rdy_n == !$past(reg_wdata[0])));

  assert_rts_write_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_MCR) |=> (req_send_n == !$past(reg_wdata[1])));

  assert_irq_oe_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_MCR) |=> (irq_drive_en == $past(reg_wdata[3]) && user_out == !$past(reg_wdata[3])));

  assert_trailing_ri_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(delta[2]) |-> (ri_prev && !$past(ri_prev)));

  assert_read_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_MSR && chg == 4'b0000) |=> (delta == 4'b0000));

  assert_modem_irq_R9: assert property (@(posedge clk) disable iff (rst)
    (ier_q[3] && delta != 4'b0000) |=> irq_level);

  assert_loop_idle_R11: assert property (@(posedge clk) disable iff (rst)
    loop_q |=> ser_tx_pin);
endmodule

bind uart_modem_ctl mdm_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .term_rdy_n(term_rdy_n), .req_send_n(req_send_n), .user_out(user_out),
  .irq_drive_en(irq_drive_en), .irq_level(irq_level), .ser_tx_pin(ser_tx_pin),
  .loop_q(mcr_q[4]), .ier_q(ier_q), .delta(msr_q[3:0]), .chg(chg),
  .ri_prev(ri_prev)
);

// File: tb/sim_uart_modem_ctl.sv
`timescale 1ns/1ps
module sim_uart_modem_ctl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic cts_n = 1, dsr_n = 1, ri_n = 1, dcd_n = 1;
  logic term_rdy_n, req_send_n, user_out, irq_drive_en, irq_level;
  logic rx_avail_req = 0, tx_space_req = 0, rx_error_req = 0;
  logic ser_tx_in = 1, ser_rx_pin = 1;
  logic ser_tx_pin, ser_rx_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_modem_ctl u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
    .term_rdy_n(term_rdy_n), .req_send_n(req_send_n), .user_out(user_out),
    .irq_drive_en(irq_drive_en), .irq_level(irq_level),
    .rx_avail_req(rx_avail_req), .tx_space_req(tx_space_req),
    .rx_error_req(rx_error_req), .ser_tx_in(ser_tx_in),
    .ser_tx_pin(ser_tx_pin), .ser_rx_pin(ser_rx_pin), .ser_rx_out(ser_rx_out)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 dtr", {7'b0, term_rdy_n}, 8'h01);
    check("R1 rts", {7'b0, req_send_n}, 8'h01);
    check("R1 user", {7'b0, user_out}, 8'h01);
    check("R1 irq_oe", {7'b0, irq_drive_en}, 8'h00);
    check("R1 irq", {7'b0, irq_level}, 8'h00);
    check("R1 txpin", {7'b0, ser_tx_pin}, 8'h01);
    rd(3'd1, v); check("R1 ier", v, 8'h00);
    rd(3'd4, v); check("R1 mcr", v, 8'h00);
    rd(3'd6, v); check("R1 msr", v, 8'h00);
  endtask

  task automatic t_dtr_rts;
    wr(3'd4, 8'h01);
    check("R2 dtr low", {7'b0, term_rdy_n}, 8'h00);
    check("R3 rts idle", {7'b0, req_send_n}, 8'h01);
    wr(3'd4, 8'h02);
    check("R2 dtr high", {7'b0, term_rdy_n}, 8'h01);
    check("R3 rts low", {7'b0, req_send_n}, 8'h00);
    wr(3'd4, 8'h00);
    check("R3 rts high", {7'b0, req_send_n}, 8'h01);
  endtask

  task automatic t_irq_pin;
    wr(3'd4, 8'h08);
    check("R4 oe on", {7'b0, irq_drive_en}, 8'h01);
    check("R4 user 0", {7'b0, user_out}, 8'h00);
    wr(3'd4, 8'h00);
    check("R4 oe off", {7'b0, irq_drive_en}, 8'h00);
    check("R4 user 1", {7'b0, user_out}, 8'h01);
  endtask

  task automatic t_readback;
    logic [7:0] v;
    wr(3'd1, 8'hFF); rd(3'd1, v); check("R12 ier", v, 8'h0F);
    wr(3'd4, 8'hFF); rd(3'd4, v); check("R12 mcr", v, 8'h1F);
    rd(3'd0, v); check("R12 addr0", v, 8'h00);
    rd(3'd7, v); check("R12 addr7", v, 8'h00);
    wr(3'd4, 8'h00); wr(3'd1, 8'h00);
  endtask

  task automatic t_levels;
    logic [7:0] v;
    cts_n = 0; dsr_n = 0; idle(6);
    rd(3'd6, v); check("R5 R6 cts dsr fall", v, 8'h33);
    rd(3'd6, v); check("R8 cleared", v, 8'h30);
    cts_n = 1; dsr_n = 1; dcd_n = 0; idle(6);
    rd(3'd6, v); check("R6 rise and dcd", v, 8'h8B);
    rd(3'd6, v); check("R8 dcd level stays", v, 8'h80);
    dcd_n = 1; idle(6);
    rd(3'd6, v); check("R6 dcd release", v, 8'h08);
    rd(3'd6, v); check("R8 empty", v, 8'h00);
  endtask

  task automatic t_ring;
    logic [7:0] v;
    ri_n = 0; idle(6);
    rd(3'd6, v); check("R7 falling no flag", v, 8'h40);
    ri_n = 1; idle(6);
    rd(3'd6, v); check("R7 trailing edge", v, 8'h04);
    rd(3'd6, v); check("R7 cleared", v, 8'h00);
  endtask

  task automatic t_modem_irq;
    logic [7:0] v;
    wr(3'd1, 8'h08); wr(3'd4, 8'h08);
    cts_n = 0; idle(7);
    check("R9 irq set", {7'b0, irq_level}, 8'h01);
    rd(3'd6, v); idle(2);
    check("R9 irq clear after read", {7'b0, irq_level}, 8'h00);
    wr(3'd1, 8'h00);
    cts_n = 1; idle(7);
    check("R9 disabled", {7'b0, irq_level}, 8'h00);
    rd(3'd6, v); check("R9 pending seen", v, 8'h01);
    wr(3'd4, 8'h00);
  endtask

  task automatic t_sources;
    wr(3'd1, 8'h01);
    rx_avail_req = 1; idle(2);
    check("R10 rx avail", {7'b0, irq_level}, 8'h01);
    rx_avail_req = 0; tx_space_req = 1; idle(2);
    check("R10 tx masked", {7'b0, irq_level}, 8'h00);
    wr(3'd1, 8'h02); idle(2);
    check("R10 tx enabled", {7'b0, irq_level}, 8'h01);
    tx_space_req = 0; rx_error_req = 1; idle(2);
    check("R10 err masked", {7'b0, irq_level}, 8'h00);
    wr(3'd1, 8'h04); idle(2);
    check("R10 err enabled", {7'b0, irq_level}, 8'h01);
    rx_error_req = 0; wr(3'd1, 8'h00); idle(2);
  endtask

  task automatic t_loop;
    ser_tx_in = 0; ser_rx_pin = 0; idle(2);
    check("R11 tx normal", {7'b0, ser_tx_pin}, 8'h00);
    check("R11 rx normal", {7'b0, ser_rx_out}, 8'h00);
    wr(3'd4, 8'h10);
    ser_tx_in = 0; ser_rx_pin = 1; idle(2);
    check("R11 tx idle", {7'b0, ser_tx_pin}, 8'h01);
    check("R11 rx from tx", {7'b0, ser_rx_out}, 8'h00);
    ser_tx_in = 1; ser_rx_pin = 0; idle(2);
    check("R11 rx pin ignored", {7'b0, ser_rx_out}, 8'h01);
    check("R11 tx still idle", {7'b0, ser_tx_pin}, 8'h01);
    wr(3'd4, 8'h00); ser_rx_pin = 1;
  endtask

  initial begin
    idle(4);
    rst = 0;
    idle(1);
    t_reset();
    t_dtr_rts();
    t_irq_pin();
    t_readback();
    t_levels();
    t_ring();
    t_modem_irq();
    t_sources();
    t_loop();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule